// File: doc/BRIEF.md
# Line Latch and Drive-Phase Controller

This block sits between the column data register of a display source driver and its analog output stage. Once per horizontal line a strobe arrives. The block copies the whole captured line of gray codes into an output latch, one code per column. While the strobe is high it keeps every column in high impedance. When the strobe is released it turns the column drive on and times a high-drive window. The window is 64 or 128 clocks long, chosen by a mode pin.

The block also tells each column which of two reference voltage groups to use. Adjacent columns always take opposite groups, and one polarity bit swaps the two. It also decodes two bias-control pins into a bias-current mode for the amplifiers. Everything is synchronous to one clock. The strobe and the pins are sampled at rising edges, and only the latch transfer happens on the falling edge. Conversion to voltages and the amplifiers themselves belong to the stage downstream.

Top module: `line_drive_ctrl`

## Requirements
- R1: When the strobe is sampled high at a rising clock edge after being sampled low at the edge before, `codes_o` takes the value of `line_data_i` present at the next falling clock edge. At every other falling edge `codes_o` keeps its value, even while the strobe stays high.
- R2: `out_en_o` (1 = drive, 0 = high impedance) goes to 0 at the rising edge that first samples the strobe high. It stays 0 for as long as the strobe is sampled high.
- R3: `out_en_o` goes to 1 at the rising edge that first samples the strobe low after it was high. It stays 1 until the next strobe.
- R4: `high_drive_o` goes to 1 at the same edge where drive starts. If `win_sel_i` is 1 at that edge, it stays 1 for exactly 64 clock cycles.
- R5: If `win_sel_i` is 0 at the edge where drive starts, `high_drive_o` stays 1 for exactly 128 clock cycles. Changes on `win_sel_i` at any other time have no effect on a running window.
- R6: A new strobe that arrives while the window is running aborts it. `high_drive_o` and `out_en_o` both drop at the edge that samples that strobe high.
- R7: `pol_i` is captured only at the edge that first samples the strobe high. In `grp_sel_o`, 0 selects the upper reference group and 1 the lower group. Bit c serves column c+1, so even bit indices are the odd columns. With the captured polarity 0, odd columns get 0 and even columns get 1. With it 1, the assignment is swapped.
- R8: `bias_mode_o` is a registered decode of `{bias_a_i, bias_b_i}` with the encoding 0 = low, 1 = normal, 2 = middle, 3 = high. The input 10 gives high, 00 gives middle, 01 gives normal and 11 gives low.
- R9: While `rst` is high at a clock edge, `codes_o` is cleared, both `out_en_o` and `high_drive_o` are 0, and `grp_sel_o` shows captured polarity 0. `bias_mode_o` is normal (1), which matches the pins' undriven defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge samples, falling edge completes the latch transfer |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Line strobe, at least two clocks high per line |
| pol_i | input | 1 | Polarity bit, captured at the strobe start |
| win_sel_i | input | 1 | Window length select: 1 = 64 clocks, 0 = 128 clocks |
| bias_a_i | input | 1 | First bias-control pin |
| bias_b_i | input | 1 | Second bias-control pin |
| line_data_i | input | NUM_COLS*CODE_W | Data register contents, column c in bits [c*CODE_W +: CODE_W] |
| codes_o | output | NUM_COLS*CODE_W | Latched gray codes, same layout |
| grp_sel_o | output | NUM_COLS | Reference group per column (0 upper, 1 lower) |
| out_en_o | output | 1 | Column drive enable (0 = high impedance) |
| high_drive_o | output | 1 | 1 during the high-drive phase, 0 in the low-drive phase |
| bias_mode_o | output | 2 | Decoded bias-current mode |

## Verification
Directed lines come first. One uses the short window and one the long window, and the second holds the strobe for three clocks while the data changes every cycle. This shows whether the latch copies the line only once and at the correct half cycle. A strobe placed inside a running window separates an abort from a window that simply runs out. All four bias-pin combinations are applied back to back to catch swapped decode entries. A few hundred random lines follow, with random pulse widths, gaps shorter and longer than both windows, and random polarity, mode and data. Each cycle is compared against a reference model written from the requirements.

// File: rtl/lldc_pkg.sv
package lldc_pkg;

    // Bias-current mode seen by the amplifier stage
    typedef enum logic [1:0] {
        BIAS_LOW    = 2'd0,
        BIAS_NORMAL = 2'd1,
        BIAS_MIDDLE = 2'd2,
        BIAS_HIGH   = 2'd3
    } bias_mode_e;

    // Strobe events and captured line state passed to the other stages
    typedef struct packed {
        logic rise;      // strobe first seen high at this edge
        logic fall;      // strobe first seen low at this edge
        logic lat_pend;  // transfer due at the coming falling edge
        logic pol;       // polarity captured at the last strobe start
    } strb_evt_t;

    function automatic bias_mode_e bias_decode(input logic pin_a, input logic pin_b);
        bias_mode_e m;
        unique case ({pin_a, pin_b})
            2'b10:   m = BIAS_HIGH;
            2'b00:   m = BIAS_MIDDLE;
            2'b01:   m = BIAS_NORMAL;
            default: m = BIAS_LOW;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lldc_strobe_seq.sv
module lldc_strobe_seq
    import lldc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe_i,
    input  logic      pol_i,
    output strb_evt_t evt_o
);

    logic strb_q;
    logic lat_pend_q;
    logic pol_q;
    logic rise_c;
    logic fall_c;

    assign rise_c = strobe_i & ~strb_q;
    assign fall_c = ~strobe_i & strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q     <= 1'b0;
            lat_pend_q <= 1'b0;
            pol_q      <= 1'b0;
        end else begin
            strb_q     <= strobe_i;
            lat_pend_q <= rise_c;
            if (rise_c) begin
                pol_q <= pol_i;
            end
        end
    end

    assign evt_o = '{rise: rise_c, fall: fall_c, lat_pend: lat_pend_q, pol: pol_q};

    // R7
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rise_c |=> $stable(pol_q));

endmodule

// File: rtl/lldc_drive_timer.sv
module lldc_drive_timer #(
    parameter int unsigned WIN_SHORT = 64,
    parameter int unsigned WIN_LONG  = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    input  logic fall_i,
    input  logic win_sel_i,
    output logic out_en_o,
    output logic high_drive_o
);

    localparam int unsigned CW = (WIN_LONG > 2) ? $clog2(WIN_LONG) : 1;
    localparam logic [CW-1:0] LOAD_SHORT = CW'(WIN_SHORT - 1);
    localparam logic [CW-1:0] LOAD_LONG  = CW'(WIN_LONG - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_en_o     <= 1'b0;
            high_drive_o <= 1'b0;
            cnt_q        <= '0;
        end else if (rise_i) begin
            out_en_o     <= 1'b0;
            high_drive_o <= 1'b0;
            cnt_q        <= '0;
        end else if (fall_i) begin
            out_en_o     <= 1'b1;
            high_drive_o <= 1'b1;
            cnt_q        <= win_sel_i ? LOAD_SHORT : LOAD_LONG;
        end else if (high_drive_o) begin
            if (cnt_q == '0) begin
                high_drive_o <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R2
    hiz_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> !out_en_o);

    // R3
    drive_start_chk: assert property (@(posedge clk) disable iff (rst)
        fall_i |=> (out_en_o && high_drive_o));

    // R6
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> !high_drive_o);

    // R4
    window_in_drive_chk: assert property (@(posedge clk) disable iff (rst)
        high_drive_o |-> out_en_o);

endmodule

// File: rtl/lldc_line_latch.sv
module lldc_line_latch #(
    parameter int unsigned NUM_COLS = 384,
    parameter int unsigned CODE_W   = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         lat_pend_i,
    input  logic                         pol_i,
    input  logic [NUM_COLS*CODE_W-1:0]   line_data_i,
    output logic [NUM_COLS*CODE_W-1:0]   codes_o,
    output logic [NUM_COLS-1:0]          grp_sel_o
);

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam logic EVEN_COLUMN = ((c % 2) == 1);
        logic [CODE_W-1:0] col_q;

        always_ff @(negedge clk) begin
            if (rst) begin
                col_q <= '0;
            end else if (lat_pend_i) begin
                col_q <= line_data_i[c*CODE_W +: CODE_W];
            end
        end

        assign codes_o[c*CODE_W +: CODE_W] = col_q;
        assign grp_sel_o[c] = pol_i ^ EVEN_COLUMN;
    end

    // R1
    codes_hold_chk: assert property (@(negedge clk) disable iff (rst)
        !lat_pend_i |=> $stable(codes_o));

endmodule

// File: rtl/line_drive_ctrl.sv
module line_drive_ctrl
    import lldc_pkg::*;
#(
    parameter int unsigned NUM_COLS  = 384,
    parameter int unsigned CODE_W    = 6,
    parameter int unsigned WIN_SHORT = 64,
    parameter int unsigned WIN_LONG  = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         strobe_i,
    input  logic                         pol_i,
    input  logic                         win_sel_i,
    input  logic                         bias_a_i,
    input  logic                         bias_b_i,
    input  logic [NUM_COLS*CODE_W-1:0]   line_data_i,
    output logic [NUM_COLS*CODE_W-1:0]   codes_o,
    output logic [NUM_COLS-1:0]          grp_sel_o,
    output logic                         out_en_o,
    output logic                         high_drive_o,
    output logic [1:0]                   bias_mode_o
);

    strb_evt_t  evt;
    bias_mode_e bias_q;

    lldc_strobe_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_i),
        .pol_i    (pol_i),
        .evt_o    (evt)
    );

    lldc_drive_timer #(
        .WIN_SHORT (WIN_SHORT),
        .WIN_LONG  (WIN_LONG)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .rise_i       (evt.rise),
        .fall_i       (evt.fall),
        .win_sel_i    (win_sel_i),
        .out_en_o     (out_en_o),
        .high_drive_o (high_drive_o)
    );

    lldc_line_latch #(
        .NUM_COLS (NUM_COLS),
        .CODE_W   (CODE_W)
    ) u_latch (
        .clk         (clk),
        .rst         (rst),
        .lat_pend_i  (evt.lat_pend),
        .pol_i       (evt.pol),
        .line_data_i (line_data_i),
        .codes_o     (codes_o),
        .grp_sel_o   (grp_sel_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bias_q <= BIAS_NORMAL;
        end else begin
            bias_q <= bias_decode(bias_a_i, bias_b_i);
        end
    end

    assign bias_mode_o = bias_q;

    // R8
    bias_high_chk: assert property (@(posedge clk) disable iff (rst)
        (bias_a_i && !bias_b_i) |=> (bias_mode_o == 2'd3));

endmodule

// File: tb/line_drive_ctrl_bench.sv
`timescale 1ns/100ps
module line_drive_ctrl_bench;

    localparam int NC = 384;
    localparam int CWD = 6;
    localparam int W = NC * CWD;

    logic clk = 1'b0;
    logic rst, strobe, pol, wsel, ba, bb;
    logic [W-1:0] data;
    logic [W-1:0] codes;
    logic [NC-1:0] grp;
    logic out_en, hd;
    logic [1:0] bias;

    always #2.5 clk = ~clk;

    line_drive_ctrl u_line_drive_ctrl (
        .clk (clk), .rst (rst), .strobe_i (strobe), .pol_i (pol),
        .win_sel_i (wsel), .bias_a_i (ba), .bias_b_i (bb),
        .line_data_i (data), .codes_o (codes), .grp_sel_o (grp),
        .out_en_o (out_en), .high_drive_o (hd), .bias_mode_o (bias)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    logic m_sq, m_lp, m_pol, m_en;
    int m_rem;
    logic [1:0] m_bias;
    logic [W-1:0] m_codes;

    function automatic logic [1:0] exp_bias(input logic a, input logic b);
        if (a && !b) return 2'd3;
        if (!a && !b) return 2'd2;
        if (!a && b) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [NC-1:0] exp_grp(input logic p);
        logic [NC-1:0] g;
        for (int c = 0; c < NC; c++) g[c] = p ^ (c % 2 == 1);
        return g;
    endfunction

    task automatic model_reset();
        m_sq = 0; m_lp = 0; m_pol = 0; m_en = 0; m_rem = 0; m_bias = 2'd1;
    endtask

    task automatic rand_data();
        for (int i = 0; i < W; i += 32) begin
            logic [31:0] r = $urandom;
            for (int b = 0; b < 32; b++) if (i + b < W) data[i+b] = r[b];
        end
    endtask

    task automatic chk1(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare();
        string t_en, t_hd, t_grp, t_bias, t_cod;
        if (rst) begin
            t_en = "R9"; t_hd = "R9"; t_grp = "R9"; t_bias = "R9"; t_cod = "R9";
        end else begin
            t_en = "R2/R3"; t_hd = "R4/R5/R6"; t_grp = "R7"; t_bias = "R8"; t_cod = "R1";
        end
        chk1(t_en, {31'd0, out_en}, {31'd0, m_en});
        chk1(t_hd, {31'd0, hd}, {31'd0, (m_rem > 0)});
        chk1(t_bias, {30'd0, bias}, {30'd0, m_bias});
        checks++;
        if (grp !== exp_grp(m_pol)) begin
            fails++;
            $display("FAIL %s: grp_sel got %0h expected %0h", t_grp, grp, exp_grp(m_pol));
        end
        checks++;
        if (codes !== m_codes) begin
            fails++;
            for (int c = 0; c < NC; c++) begin
                if (codes[c*CWD +: CWD] !== m_codes[c*CWD +: CWD]) begin
                    $display("FAIL %s: column %0d code got %0h expected %0h", t_cod, c,
                             codes[c*CWD +: CWD], m_codes[c*CWD +: CWD]);
                    break;
                end
            end
        end
    endtask

    // inputs are already set (posedge + 1); sample after the falling edge
    task automatic run_cycle();
        logic rise, fall;
        @(negedge clk);
        if (rst) m_codes = '0;
        else if (m_lp) m_codes = data;
        #1;
        compare();
        if (rst) begin
            model_reset();
        end else begin
            rise = strobe & ~m_sq;
            fall = ~strobe & m_sq;
            m_lp = rise;
            if (rise) m_pol = pol;
            if (rise) begin
                m_en = 0; m_rem = 0;
            end else if (fall) begin
                m_en = 1; m_rem = wsel ? 64 : 128;
            end else if (m_rem > 0) begin
                m_rem--;
            end
            m_bias = exp_bias(ba, bb);
            m_sq = strobe;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) run_cycle();
    endtask

    // strobe high for 'width' cycles, new data each cycle (R1 one-shot transfer)
    task automatic line(input int width, input logic p, input logic ws);
        pol = p; wsel = ws;
        for (int i = 0; i < width; i++) begin
            strobe = 1; rand_data(); run_cycle();
            pol = ~p; wsel = ~ws;
        end
        strobe = 0; wsel = ~ws;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1; strobe = 0; pol = 0; wsel = 1; ba = 0; bb = 1; data = '0;
        model_reset(); m_codes = '0;
        @(posedge clk); #1;
        idle(3);                        // R9 reset values
        rst = 0;
        idle(2);
        line(2, 0, 1); idle(80);        // R4 short window, R7 pol 0
        line(3, 1, 0); idle(140);       // R5 long window, R1 one-shot, R7 swapped
        line(2, 0, 1); idle(30);        // R6 abort mid-window
        line(2, 1, 0); idle(20);
        line(4, 0, 1); idle(70);
        ba = 1; bb = 0; run_cycle();    // R8 all combos
        ba = 0; bb = 0; run_cycle();
        ba = 0; bb = 1; run_cycle();
        ba = 1; bb = 1; run_cycle();
        run_cycle();
        for (int k = 0; k < 300; k++) begin
            int gap = $urandom % 160;
            ba = 1'($urandom); bb = 1'($urandom);
            line(2 + ($urandom % 3), 1'($urandom), 1'($urandom));
            for (int g = 0; g < gap; g++) begin
                if (g % 37 == 0) begin ba = 1'($urandom); bb = 1'($urandom); wsel = 1'($urandom); end
                run_cycle();
            end
        end
        rst = 1; idle(2);               // R9 reset mid-run
        rst = 0; idle(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule